// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration port of a mixed-signal front end. It has three wires: a load strobe, a serial clock and a serial data line. A host sends one frame while the load strobe is low. The frame holds a read/write flag, a 3-bit register address and up to ten data bits, all least significant bit first. On a write, the frame is committed to the addressed register when the load strobe rises again. On a read, the port returns the addressed register on a separate serial output.

The port holds a small register file and decodes it into parallel control fields:
- operating mode, output mode, clock polarity, power-down mode and clamp-level selection;
- a gain code;
- two 8-bit auxiliary converter codes;
- an offset-correction enable and a run flag for the auxiliary converters.

The analog functions these fields steer are outside the block.

The three serial pins are treated as asynchronous. They are resynchronised into a fast system clock, and every serial edge is found there. The serial clock must therefore run well below the system clock.

Top module: `sif_ctrl_port`

## Requirements
- R1: After reset, `op_mode` is 2'b11 (image-sensor mode). Every other control output is 0, including `aux_dac_run`, so the auxiliary converters start stopped. `sdo_oe` is 0.
- R2: A frame is sampled on rising serial-clock edges in this order: flag, address bit 0..2, then data bit 0..9. Flag 0 means write. Address 0 is the control register, with the layout [1:0] `op_mode`, [3:2] `out_mode`, [5:4] `clk_pol`, [7:6] `pwr_mode`, [9:8] clamp select.
- R3: A write changes no output until the load strobe rises, and it is applied only then.
- R4: Serial-clock edges after the 14th in one frame are ignored, so a 16-edge frame with two trailing dummy bits writes the same value as a 14-edge frame.
- R5: A write frame with no clock edges, or with fewer than 14 edges, is discarded and leaves every register unchanged. The one exception is the short gain write of R7.
- R6: A frame with flag 1 is a read and changes no register. While the load strobe is low, `sdo_oe` is 1 from the first falling edge after the third address bit. On that falling edge and the nine that follow, `sdo` presents register bits 0 to 9 in turn. Otherwise `sdo_oe` is 0.
- R7: When `op_mode` is 2'b01 (auxiliary mode), a write to the gain register (address 1) is accepted with at least 12 edges, which is 8 data bits. Only bits 7:0 are stored and bits 9:8 become 0. In any other mode, a 12-edge gain write is discarded.
- R8: When `op_mode` is 2'b10 (mid-scale auxiliary mode), `gain_code` bit 9 reads 0 on the output. A read of the gain register still returns all ten stored bits.
- R9: `clamp_code` follows the clamp select: 00 gives 32, 01 gives 48, 10 gives 64 and 11 gives 16.
- R10: Addresses 5 to 7 hold no register. Writes to them change no output, and reads of them return 0.
- R11: Address 2 sets `aux_dac_a` from data bits 7:0. Address 3 sets `aux_dac_b` from data bits 7:0. At address 4, bit 0 sets `offset_corr_en` and bit 1 sets `aux_dac_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sload | input | 1 | Load strobe; a frame runs while it is low, and a write commits when it rises |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for `sdo`; the pad is released when it is 0 |
| op_mode | output | 2 | Operating mode |
| out_mode | output | 2 | Output mode field |
| clk_pol | output | 2 | Clock and clamp pulse polarity field |
| pwr_mode | output | 2 | Power-down mode field |
| clamp_code | output | 7 | Decoded black clamp level in output codes |
| gain_code | output | 10 | Gain code, masked to 9 bits in mid-scale auxiliary mode |
| aux_dac_a | output | 8 | First auxiliary converter code |
| aux_dac_b | output | 8 | Second auxiliary converter code |
| offset_corr_en | output | 1 | Offset-correction enable |
| aux_dac_run | output | 1 | Auxiliary converters running (0 = stopped) |

## Verification
The assertions assume that each serial pin holds each level for several system clocks. Under that assumption the resynchronised load strobe and serial clock never change in the same cycle, and no serial edge is missed. The bench keeps every serial pin level for six system clocks, and it changes the data line only while the serial clock is low. It also waits several cycles after the last falling edge before raising the load strobe. Under these conditions, the edge counter and the commit pulse see the frame exactly as it was sent.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 10;
    localparam int DAC_W       = 8;
    localparam int SHORT_W     = 8;
    localparam int MID_GAIN_W  = 9;
    localparam int CLAMP_W     = 7;
    localparam int SYNC_STAGES = 2;

    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int SHORT_BITS = HDR_BITS + SHORT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_GAIN = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_DACA = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_DACB = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ADR_MISC = ADDR_W'(4);

    localparam logic [DATA_W-1:0] MID_MASK = DATA_W'((1 << MID_GAIN_W) - 1);

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_AUX    = 2'b01,
        MODE_MID    = 2'b10,
        MODE_IMAGE  = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic [1:0] clamp_sel;
        logic [1:0] pwr;
        logic [1:0] clk_pol;
        logic [1:0] out_mode;
        op_mode_e   op;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{clamp_sel: 2'b00, pwr: 2'b00,
                                       clk_pol: 2'b00, out_mode: 2'b00,
                                       op: MODE_IMAGE};

    function automatic logic [CLAMP_W-1:0] clamp_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return CLAMP_W'(32);
            2'b01:   return CLAMP_W'(48);
            2'b10:   return CLAMP_W'(64);
            default: return CLAMP_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{INIT}};
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lvl,
    input  logic              load_rise,
    input  logic              sclk_rise,
    input  logic              sdi_lvl,
    input  logic              short_ok,
    output logic [CNT_W-1:0]  cnt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              rd_active
);
    logic [FRAME_BITS-1:0] sh;
    logic rnw, full, short_len;

    // Frame is live while the strobe is low; idle strobe clears the capture.
    always_ff @(posedge clk) begin
        if (rst || load_lvl) begin
            cnt <= '0;
            sh  <= '0;
        end else if (sclk_rise && (cnt < CNT_W'(FRAME_BITS))) begin
            sh[cnt] <= sdi_lvl;
            cnt     <= cnt + CNT_W'(1);
        end
    end

    assign rnw       = sh[0];
    assign addr      = sh[HDR_BITS-1:1];
    assign data      = sh[FRAME_BITS-1:HDR_BITS];
    assign full      = (cnt == CNT_W'(FRAME_BITS));
    assign short_len = short_ok && (cnt >= CNT_W'(SHORT_BITS));
    assign wr_en     = load_rise && !rnw && (full || short_len);
    assign rd_active = rnw && !load_lvl && (cnt >= CNT_W'(HDR_BITS));

    assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS));

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (rst)
        load_lvl |=> (cnt == '0));
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile
    import sif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               short_ok,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         op_mode,
    output logic [1:0]         out_mode,
    output logic [1:0]         clk_pol,
    output logic [1:0]         pwr_mode,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic [DATA_W-1:0]  gain_code,
    output logic [DAC_W-1:0]   aux_dac_a,
    output logic [DAC_W-1:0]   aux_dac_b,
    output logic               offset_corr_en,
    output logic               aux_dac_run
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] gain_q;
    logic [DAC_W-1:0]  daca_q, dacb_q;
    logic              offs_q, run_q;

    assign short_ok = (ctrl_q.op == MODE_AUX) && (addr == ADR_GAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_DEFAULT;
            gain_q <= '0;
            daca_q <= '0;
            dacb_q <= '0;
            offs_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: ctrl_q <= ctrl_t'(wr_data);
                ADR_GAIN: gain_q <= short_ok ? DATA_W'(wr_data[SHORT_W-1:0]) : wr_data;
                ADR_DACA: daca_q <= wr_data[DAC_W-1:0];
                ADR_DACB: dacb_q <= wr_data[DAC_W-1:0];
                ADR_MISC: begin
                    offs_q <= wr_data[0];
                    run_q  <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_CTRL: rdata = ctrl_q;
            ADR_GAIN: rdata = gain_q;
            ADR_DACA: rdata = DATA_W'(daca_q);
            ADR_DACB: rdata = DATA_W'(dacb_q);
            ADR_MISC: rdata = DATA_W'({run_q, offs_q});
            default:  rdata = '0;
        endcase
    end

    assign op_mode        = ctrl_q.op;
    assign out_mode       = ctrl_q.out_mode;
    assign clk_pol        = ctrl_q.clk_pol;
    assign pwr_mode       = ctrl_q.pwr;
    assign clamp_code     = clamp_level(ctrl_q.clamp_sel);
    assign gain_code      = (ctrl_q.op == MODE_MID) ? (gain_q & MID_MASK) : gain_q;
    assign aux_dac_a      = daca_q;
    assign aux_dac_b      = dacb_q;
    assign offset_corr_en = offs_q;
    assign aux_dac_run    = run_q;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_DEFAULT && gain_q == '0 && !run_q));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctrl_q) && $stable(gain_q) && $stable(daca_q)
                    && $stable(dacb_q) && $stable(run_q) && $stable(offs_q)));
endmodule

// File: rtl/sif_rd_drv.sv
module sif_rd_drv
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lvl,
    input  logic              sclk_fall,
    input  logic              rd_active,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [CNT_W-1:0] idx;

    assign idx = cnt - CNT_W'(HDR_BITS);

    always_ff @(posedge clk) begin
        if (rst || load_lvl) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (sclk_fall && rd_active) begin
            sdo_oe <= 1'b1;
            if (idx < CNT_W'(DATA_W)) begin
                sdo <= rdata[idx];
            end
        end
    end

    assert_oe_frame_R6: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !$past(load_lvl));
endmodule

// File: rtl/sif_ctrl_port.sv
module sif_ctrl_port
    import sif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sload,
    input  logic               sclk,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [1:0]         op_mode,
    output logic [1:0]         out_mode,
    output logic [1:0]         clk_pol,
    output logic [1:0]         pwr_mode,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic [DATA_W-1:0]  gain_code,
    output logic [DAC_W-1:0]   aux_dac_a,
    output logic [DAC_W-1:0]   aux_dac_b,
    output logic               offset_corr_en,
    output logic               aux_dac_run
);
    logic [2:0]        pin_s;
    logic [1:0]        prv;
    logic              load_lvl, sclk_lvl, sdi_lvl;
    logic              load_rise, sclk_rise, sclk_fall;
    logic [CNT_W-1:0]  cnt;
    logic              wr_en, rd_active, short_ok;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data, rdata;

    sif_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
        .clk(clk), .rst(rst), .din({sdi, sclk, sload}), .dout(pin_s)
    );

    assign load_lvl = pin_s[0];
    assign sclk_lvl = pin_s[1];
    assign sdi_lvl  = pin_s[2];

    always_ff @(posedge clk) begin
        if (rst) prv <= 2'b01;
        else     prv <= {sclk_lvl, load_lvl};
    end

    assign load_rise = load_lvl & ~prv[0];
    assign sclk_rise = sclk_lvl & ~prv[1];
    assign sclk_fall = ~sclk_lvl & prv[1];

    sif_shifter u_shift (
        .clk(clk), .rst(rst), .load_lvl(load_lvl), .load_rise(load_rise),
        .sclk_rise(sclk_rise), .sdi_lvl(sdi_lvl), .short_ok(short_ok),
        .cnt(cnt), .wr_en(wr_en), .addr(addr), .data(wr_data),
        .rd_active(rd_active)
    );

    sif_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .short_ok(short_ok), .rdata(rdata), .op_mode(op_mode),
        .out_mode(out_mode), .clk_pol(clk_pol), .pwr_mode(pwr_mode),
        .clamp_code(clamp_code), .gain_code(gain_code),
        .aux_dac_a(aux_dac_a), .aux_dac_b(aux_dac_b),
        .offset_corr_en(offset_corr_en), .aux_dac_run(aux_dac_run)
    );

    sif_rd_drv u_rd (
        .clk(clk), .rst(rst), .load_lvl(load_lvl), .sclk_fall(sclk_fall),
        .rd_active(rd_active), .cnt(cnt), .rdata(rdata),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    assert_no_write_idle_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!load_lvl));
endmodule

// File: tb/tb_sif_ctrl_port.sv
module tb_sif_ctrl_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sload = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [1:0] op_mode, out_mode, clk_pol, pwr_mode;
    logic [6:0] clamp_code;
    logic [9:0] gain_code;
    logic [7:0] aux_dac_a, aux_dac_b;
    logic offset_corr_en, aux_dac_run;

    always #10 clk = ~clk;

    sif_ctrl_port dut (.*);

    typedef struct {
        string      req;
        logic [43:0] exp;
        bit         rd;
        logic [9:0] rexp;
        logic [9:0] rgot;
        bit         oe_ok;
    } item_t;

    item_t q[$];
    int total = 0, fails = 0;
    bit done = 1'b0;

    logic [9:0] s_ctrl = 10'b00_00_00_00_11;
    logic [9:0] s_gain = '0;
    logic [7:0] s_da = '0, s_db = '0;
    logic [1:0] s_misc = '0;

    function automatic logic [6:0] clamp_of(input logic [1:0] s);
        case (s)
            2'b00: return 7'd32;
            2'b01: return 7'd48;
            2'b10: return 7'd64;
            default: return 7'd16;
        endcase
    endfunction

    function automatic logic [43:0] snap_exp();
        logic [9:0] g;
        g = (s_ctrl[1:0] == 2'b10) ? {1'b0, s_gain[8:0]} : s_gain;
        return {s_ctrl[1:0], s_ctrl[3:2], s_ctrl[5:4], s_ctrl[7:6],
                clamp_of(s_ctrl[9:8]), g, s_da, s_db, s_misc[0], s_misc[1], 1'b0};
    endfunction

    function automatic logic [43:0] snap_act();
        return {op_mode, out_mode, clk_pol, pwr_mode, clamp_code, gain_code,
                aux_dac_a, aux_dac_b, offset_corr_en, aux_dac_run, sdo_oe};
    endfunction

    task automatic push_state(input string req);
        item_t it;
        it.req = req; it.exp = snap_exp(); it.rd = 1'b0;
        it.rexp = '0; it.rgot = '0; it.oe_ok = 1'b1;
        q.push_back(it);
    endtask

    // Monitor: pops expected items and compares against the live ports.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [43:0] a;
                it = q.pop_front();
                a = snap_act();
                total++;
                if (it.rd) begin
                    if (it.rgot !== it.rexp || !it.oe_ok) begin
                        fails++;
                        $display("FAIL %s: read got %h oe_ok %0d expected %h oe_ok 1",
                                 it.req, it.rgot, it.oe_ok, it.rexp);
                    end
                end else if (a !== it.exp) begin
                    fails++;
                    $display("FAIL %s: outputs got %h expected %h", it.req, a, it.exp);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit rnw, input logic [2:0] a, input logic [9:0] d,
                         input int nedges, input string mid_req,
                         output logic [9:0] rd, output bit oe_ok);
        logic [15:0] b;
        b = {2'b11, d, a, rnw};
        rd = '0;
        oe_ok = 1'b1;
        sload = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nedges; i++) begin
            sdi = b[i];
            wait_clk(6);
            if (i >= 4 && i < 14) begin
                rd[i-4] = sdo;
                if (!sdo_oe) oe_ok = 1'b0;
            end
            sclk = 1'b1;
            wait_clk(6);
            sclk = 1'b0;
        end
        wait_clk(6);
        if (mid_req != "") push_state(mid_req);
        wait_clk(2);
        sload = 1'b1;
        wait_clk(12);
    endtask

    task automatic apply(input logic [2:0] a, input logic [9:0] d);
        case (a)
            3'd0: s_ctrl = d;
            3'd1: s_gain = (s_ctrl[1:0] == 2'b01) ? {2'b00, d[7:0]} : d;
            3'd2: s_da = d[7:0];
            3'd3: s_db = d[7:0];
            3'd4: s_misc = d[1:0];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [9:0] d, input string req);
        logic [9:0] r; bit o;
        frame(1'b0, a, d, 14, "", r, o);
        apply(a, d);
        push_state(req);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [9:0] exp, input string req);
        logic [9:0] r; bit o;
        item_t it;
        frame(1'b1, a, 10'h3FF, 14, "", r, o);
        it.req = req; it.exp = '0; it.rd = 1'b1;
        it.rexp = exp; it.rgot = r; it.oe_ok = o;
        q.push_back(it);
        push_state(req);
    endtask

    initial begin
        logic [9:0] r; bit o;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        push_state("R1 reset defaults");

        // R2 R3 R9: control write, mid-frame outputs must still hold old values
        frame(1'b0, 3'd0, 10'b01_11_10_01_00, 14, "R3 no change before strobe rise", r, o);
        apply(3'd0, 10'b01_11_10_01_00);
        push_state("R2 control fields after commit, R9 clamp 48");

        // R9: every clamp select
        for (int s = 0; s < 4; s++) begin
            wr(3'd0, {2'(s), 8'b00_00_00_11}, "R9 clamp level decode");
        end

        // R4: 16-edge frame with trailing dummy ones
        frame(1'b0, 3'd1, 10'h2A5, 16, "", r, o);
        apply(3'd1, 10'h2A5);
        push_state("R4 16-edge frame writes gain");

        // R5: short and empty write frames discarded
        frame(1'b0, 3'd1, 10'h111, 10, "", r, o);
        push_state("R5 10-edge frame discarded");
        frame(1'b0, 3'd0, 10'h000, 0, "", r, o);
        push_state("R5 empty frame discarded");

        // R7: 12-edge gain write outside auxiliary mode is dropped
        frame(1'b0, 3'd1, 10'h0C7, 12, "", r, o);
        push_state("R7 short gain write dropped in image mode");

        // R7: auxiliary mode accepts the 8-bit payload
        wr(3'd0, 10'b00_00_00_00_01, "R2 select auxiliary mode");
        frame(1'b0, 3'd1, 10'h3C7, 12, "", r, o);
        apply(3'd1, 10'h3C7);
        push_state("R7 short gain write in auxiliary mode");

        // R8: mid-scale mode masks bit 9 on the output only
        wr(3'd0, 10'b00_00_00_00_10, "R2 select mid-scale mode");
        wr(3'd1, 10'h3FF, "R8 gain output masked to 9 bits");
        rd_chk(3'd1, 10'h3FF, "R8 gain readback full 10 bits");

        // R11: converter codes and misc bits
        wr(3'd2, 10'h0A5, "R11 first converter code");
        wr(3'd3, 10'h35A, "R11 second converter code");
        wr(3'd4, 10'h003, "R11 offset enable and converter run");
        rd_chk(3'd2, 10'h0A5, "R6 readback of converter code");

        // R6: control readback, no state change
        wr(3'd0, 10'b10_01_11_00_11, "R2 control rewrite");
        rd_chk(3'd0, 10'b10_01_11_00_11, "R6 control readback LSB first");
        rd_chk(3'd4, 10'h003, "R6 misc readback");

        // R10: unmapped addresses
        frame(1'b0, 3'd5, 10'h3FF, 14, "", r, o);
        push_state("R10 write to address 5 has no effect");
        frame(1'b0, 3'd7, 10'h155, 14, "", r, o);
        push_state("R10 write to address 7 has no effect");
        rd_chk(3'd5, 10'h000, "R10 read of address 5 is zero");

        wait_clk(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule